// File: doc/BRIEF.md
# Pseudo-Random Sequence Lock Monitor

This block watches several independent sample streams, one per channel, each expected to carry a pseudo-random test sequence. Every sample holds a group of consecutive sequence bits, the earliest bit in the most significant position. Per channel, software picks a short (9-stage) or long (23-stage) sequence. The monitor predicts each incoming sample from the bits that came before it and compares. It keeps a lock state with hysteresis: a long run of failures is needed to lose lock, and a shorter run of successes regains it.

While the monitor is out of lock, its prediction history is fed from the received bits, so it locks onto any phase of the sequence without being told where the stream starts. Once it is locked, the history is fed from its own predicted bits, so a single bad sample is reported without disturbing later comparisons. Two sticky, write-one-to-clear flags per channel report the lock loss and the isolated errors. Two summary outputs OR the flags of all channels together.

Top module: `pnmon_top`

## Requirements
- R1: After synchronous reset every lost-lock flag reads 1, every error flag reads 0, the lost-lock summary reads 1 and the error summary reads 0.
- R2: With the per-channel sequence select at 0, sequence bit n equals bit n-9 XOR bit n-5. With the select at 1, bit n equals bit n-23 XOR bit n-18. Within a sample, bit SMP_W-1 is the earliest bit. A stream of the type that was not selected never locks.
- R3: While out of lock, the prediction history takes the received bits. While locked, it takes the predicted bits, so a corrupted sample does not disturb the checks on the samples after it.
- R4: An out-of-lock channel becomes locked on the 16th consecutive matching valid sample. Any mismatch restarts the match run from zero.
- R5: A locked channel loses lock on the 64th consecutive mismatching valid sample, and its lost-lock flag is 1 in the cycle after that sample. A single match restarts the mismatch run from zero.
- R6: The error flag sets on a mismatching valid sample that arrives while the channel is locked. It is held at 0 in every cycle in which the lost-lock flag is 1.
- R7: A clear strobe of 1 clears its flag in the next cycle. A lost-lock clear has no effect while the channel is out of lock, and a new error event takes priority over an error clear in the same cycle.
- R8: A cycle with the channel's valid at 0 changes neither the flags, nor the run counts, nor the prediction history, whatever the data.
- R9: Each summary output equals the OR over all channels of the matching flag, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | NUM_CH | Per-channel sample valid |
| smp_data | input | NUM_CH*SMP_W | Samples; channel c is at bits [c*SMP_W +: SMP_W] |
| pn_long | input | NUM_CH | Sequence select per channel: 0 = 9-stage, 1 = 23-stage |
| clr_err | input | NUM_CH | Write-one-to-clear strobe for the error flags |
| clr_oos | input | NUM_CH | Write-one-to-clear strobe for the lost-lock flags |
| oos_flag | output | NUM_CH | Sticky lost-lock flags |
| err_flag | output | NUM_CH | Sticky error flags, gated by lock |
| any_oos | output | 1 | OR of all lost-lock flags, registered |
| any_err | output | 1 | OR of all error flags, registered |

## Verification
The bench builds the block with two channels and 8-bit samples, and keeps the lock thresholds at 64 and 16. A narrow sample forces the long sequence to fill its history from three samples, so prediction and reseeding run across sample boundaries. With two channels, one stream can run while the other stays idle. The bench sweeps both channels and both sequence types through the full cycle: locking, isolated errors, runs of 63 mismatches that a single match breaks, the loss of lock on the 64th, relocking, and a switch of sequence type. A reference model built from the requirements predicts all four outputs, and the bench compares them with the block in every cycle.

// File: rtl/pnmon_pkg.sv
package pnmon_pkg;
  // history depth covers the longest generator
  localparam int HIST_W = 23;
  // feedback taps, written as distance back into the bit stream
  localparam int SHORT_TAP_A = 9;
  localparam int SHORT_TAP_B = 5;
  localparam int LONG_TAP_A  = 23;
  localparam int LONG_TAP_B  = 18;

  typedef enum logic {
    SEQ_SHORT = 1'b0,
    SEQ_LONG  = 1'b1
  } seq_kind_e;
endpackage

// File: rtl/pnmon_predict.sv
module pnmon_predict
  import pnmon_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic              long_i,
  input  logic [SMP_W-1:0]  rx_i,
  input  logic              use_rx_i,
  output logic [SMP_W-1:0]  expect_o,
  output logic [HIST_W-1:0] hist_o
);
  // history bit 0 is the most recent bit; distance k sits at bit k-1
  logic [HIST_W-1:0] gen_h [SMP_W+1];
  logic [HIST_W-1:0] rx_h  [SMP_W+1];

  assign gen_h[0] = hist_i;
  assign rx_h[0]  = hist_i;

  for (genvar i = 0; i < SMP_W; i++) begin : g_step
    logic fb;
    assign fb = (seq_kind_e'(long_i) == SEQ_LONG)
              ? (gen_h[i][LONG_TAP_A-1]  ^ gen_h[i][LONG_TAP_B-1])
              : (gen_h[i][SHORT_TAP_A-1] ^ gen_h[i][SHORT_TAP_B-1]);
    assign expect_o[SMP_W-1-i] = fb;
    assign gen_h[i+1] = {gen_h[i][HIST_W-2:0], fb};
    assign rx_h[i+1]  = {rx_h[i][HIST_W-2:0], rx_i[SMP_W-1-i]};
  end

  assign hist_o = use_rx_i ? rx_h[SMP_W] : gen_h[SMP_W];
endmodule

// File: rtl/pnmon_runtrack.sv
module pnmon_runtrack #(
  parameter int LOSE_RUN = 64,
  parameter int LOCK_RUN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic hit_i,
  output logic oos_o,
  output logic oos_nxt_o
);
  localparam int MW = $clog2(LOSE_RUN + 1);
  localparam int LW = $clog2(LOCK_RUN + 1);
  localparam logic [MW-1:0] MISS_MAX = MW'(LOSE_RUN);
  localparam logic [LW-1:0] HIT_MAX  = LW'(LOCK_RUN);

  logic [MW-1:0] miss_q, miss_n;
  logic [LW-1:0] hit_q, hit_n;
  logic          oos_q, oos_n;

  always_comb begin
    miss_n = miss_q;
    hit_n  = hit_q;
    oos_n  = oos_q;
    if (valid_i) begin
      if (hit_i) begin
        miss_n = '0;
        hit_n  = (hit_q == HIT_MAX) ? hit_q : hit_q + 1'b1;
        if (oos_q && (hit_n == HIT_MAX)) oos_n = 1'b0;
      end else begin
        hit_n  = '0;
        miss_n = (miss_q == MISS_MAX) ? miss_q : miss_q + 1'b1;
        if (!oos_q && (miss_n == MISS_MAX)) oos_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q <= '0;
      hit_q  <= '0;
      oos_q  <= 1'b1;
    end else begin
      miss_q <= miss_n;
      hit_q  <= hit_n;
      oos_q  <= oos_n;
    end
  end

  assign oos_o     = oos_q;
  assign oos_nxt_o = oos_n;
endmodule

// File: rtl/pnmon_channel.sv
module pnmon_channel
  import pnmon_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int LOSE_RUN = 64,
  parameter int LOCK_RUN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             long_i,
  input  logic             clr_err_i,
  input  logic             clr_oos_i,
  output logic             oos_flag_o,
  output logic             err_flag_o
);
  logic [HIST_W-1:0] hist_q, hist_n;
  logic [SMP_W-1:0]  expect_w;
  logic              hit_w, oos_w, oos_nxt_w;
  logic              oflag_q, oflag_n, eflag_q, eflag_n;

  pnmon_predict #(.SMP_W(SMP_W)) u_pred (
    .hist_i   (hist_q),
    .long_i   (long_i),
    .rx_i     (data_i),
    .use_rx_i (oos_w),
    .expect_o (expect_w),
    .hist_o   (hist_n)
  );

  assign hit_w = (data_i == expect_w);

  pnmon_runtrack #(.LOSE_RUN(LOSE_RUN), .LOCK_RUN(LOCK_RUN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .hit_i     (hit_w),
    .oos_o     (oos_w),
    .oos_nxt_o (oos_nxt_w)
  );

  always_comb begin
    oflag_n = oos_nxt_w | (oflag_q & ~clr_oos_i);
    if (oflag_n) eflag_n = 1'b0;
    else eflag_n = (valid_i & ~oos_w & ~hit_w) | (eflag_q & ~clr_err_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      oflag_q <= 1'b1;
      eflag_q <= 1'b0;
    end else begin
      if (valid_i) hist_q <= hist_n;
      oflag_q <= oflag_n;
      eflag_q <= eflag_n;
    end
  end

  assign oos_flag_o = oflag_q;
  assign err_flag_o = eflag_q;
endmodule

// File: rtl/pnmon_top.sv
module pnmon_top #(
  parameter int NUM_CH   = 4,
  parameter int SMP_W    = 16,
  parameter int LOSE_RUN = 64,
  parameter int LOCK_RUN = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       smp_valid,
  input  logic [NUM_CH*SMP_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]       pn_long,
  input  logic [NUM_CH-1:0]       clr_err,
  input  logic [NUM_CH-1:0]       clr_oos,
  output logic [NUM_CH-1:0]       oos_flag,
  output logic [NUM_CH-1:0]       err_flag,
  output logic                    any_oos,
  output logic                    any_err
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pnmon_channel #(
      .SMP_W(SMP_W), .LOSE_RUN(LOSE_RUN), .LOCK_RUN(LOCK_RUN)
    ) u_ch (
      .clk        (clk),
      .rst        (rst),
      .valid_i    (smp_valid[c]),
      .data_i     (smp_data[c*SMP_W +: SMP_W]),
      .long_i     (pn_long[c]),
      .clr_err_i  (clr_err[c]),
      .clr_oos_i  (clr_oos[c]),
      .oos_flag_o (oos_flag[c]),
      .err_flag_o (err_flag[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_oos <= 1'b1;
      any_err <= 1'b0;
    end else begin
      any_oos <= |oos_flag;
      any_err <= |err_flag;
    end
  end
endmodule

// File: rtl/pnmon_checker.sv
module pnmon_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] smp_valid,
  input logic [NUM_CH-1:0] clr_err,
  input logic [NUM_CH-1:0] clr_oos,
  input logic [NUM_CH-1:0] oos_flag,
  input logic [NUM_CH-1:0] err_flag,
  input logic              any_oos,
  input logic              any_err
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_ERR_GATED_BY_LOCK: assert property (@(posedge clk) disable iff (rst) oos_flag[i] |-> !err_flag[i]); // R6
    AST_ERR_RISE_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst) $rose(err_flag[i]) |-> $past(smp_valid[i])); // R6
    AST_LOSS_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst) $rose(oos_flag[i]) |-> $past(smp_valid[i])); // R5
    AST_OOS_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst) $fell(oos_flag[i]) |-> $past(clr_oos[i])); // R7
    AST_ERR_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst) $fell(err_flag[i]) |-> ($past(clr_err[i]) || oos_flag[i])); // R7
    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst) (!smp_valid[i] && !clr_err[i] && !clr_oos[i]) |=> ($stable(oos_flag[i]) && $stable(err_flag[i]))); // R8
  end
  AST_SUMMARY_OOS: assert property (@(posedge clk) disable iff (rst) any_oos == $past(|oos_flag)); // R9
  AST_SUMMARY_ERR: assert property (@(posedge clk) disable iff (rst) any_err == $past(|err_flag)); // R9
endmodule

bind pnmon_top pnmon_checker #(.NUM_CH(NUM_CH)) u_pnmon_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .clr_err(clr_err), .clr_oos(clr_oos),
  .oos_flag(oos_flag), .err_flag(err_flag), .any_oos(any_oos), .any_err(any_err)
);

// File: tb/pnmon_top_test.sv
`timescale 1ns/1ps
module pnmon_top_test;
  localparam int NC = 2;
  localparam int W  = 8;
  localparam int HW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]   smp_valid = '0;
  logic [NC*W-1:0] smp_data  = '0;
  logic [NC-1:0]   pn_long   = '0;
  logic [NC-1:0]   clr_err   = '0;
  logic [NC-1:0]   clr_oos   = '0;
  logic [NC-1:0]   oos_flag, err_flag;
  logic            any_oos, any_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  pnmon_top #(.NUM_CH(NC), .SMP_W(W), .LOSE_RUN(64), .LOCK_RUN(16)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .pn_long(pn_long),
    .clr_err(clr_err), .clr_oos(clr_oos), .oos_flag(oos_flag), .err_flag(err_flag),
    .any_oos(any_oos), .any_err(any_err)
  );

  // reference model state, built from the requirements
  logic [HW-1:0] m_hist [NC];
  int            m_hit  [NC];
  int            m_miss [NC];
  logic [NC-1:0] m_lost, m_oflag, m_eflag;
  logic          m_any_o, m_any_e;
  // stimulus generators
  logic [HW-1:0] g_hist [NC];

  function automatic logic [W-1:0] f_pred(input logic [HW-1:0] h, input logic lng,
                                          output logic [HW-1:0] hn);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) begin
      logic b;
      b = lng ? (h[22] ^ h[17]) : (h[8] ^ h[4]);   // R2 taps n-23/n-18, n-9/n-5
      v[W-1-i] = b;
      h = {h[HW-2:0], b};
    end
    hn = h;
    return v;
  endfunction

  function automatic logic [HW-1:0] f_seed(input logic [HW-1:0] h, input logic [W-1:0] d);
    for (int i = 0; i < W; i++) h = {h[HW-2:0], d[W-1-i]};
    return h;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_hist[c] = '0; m_hit[c] = 0; m_miss[c] = 0;
    end
    m_lost = '1; m_oflag = '1; m_eflag = '0; m_any_o = 1'b1; m_any_e = 1'b0;
  endtask

  task automatic model_step();
    logic [HW-1:0] hn;
    logic [W-1:0]  ex;
    logic          hit, lost_n, of_n;
    m_any_o = |m_oflag;   // R9 one cycle behind the flags
    m_any_e = |m_eflag;
    for (int c = 0; c < NC; c++) begin
      lost_n = m_lost[c];
      hit = 1'b0;
      if (smp_valid[c]) begin
        ex  = f_pred(m_hist[c], pn_long[c], hn);
        hit = (smp_data[c*W +: W] == ex);
        m_hist[c] = m_lost[c] ? f_seed(m_hist[c], smp_data[c*W +: W]) : hn;   // R3
        if (hit) begin
          m_miss[c] = 0; m_hit[c] = (m_hit[c] < 16) ? m_hit[c] + 1 : 16;
          if (m_lost[c] && m_hit[c] == 16) lost_n = 1'b0;                     // R4
        end else begin
          m_hit[c] = 0; m_miss[c] = (m_miss[c] < 64) ? m_miss[c] + 1 : 64;
          if (!m_lost[c] && m_miss[c] == 64) lost_n = 1'b1;                   // R5
        end
      end
      of_n = lost_n | (m_oflag[c] & ~clr_oos[c]);                             // R7
      m_eflag[c] = of_n ? 1'b0
                 : ((smp_valid[c] & ~m_lost[c] & ~hit) | (m_eflag[c] & ~clr_err[c])); // R6
      m_oflag[c] = of_n;
      m_lost[c]  = lost_n;
    end
  endtask

  // one clock: inputs already set; model follows the edge, outputs compared at negedge
  task automatic tick(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, 32'(oos_flag), 32'(m_oflag));
    check(req, 32'(err_flag), 32'(m_eflag));
    check("R9", 32'(any_oos), 32'(m_any_o));
    check("R9", 32'(any_err), 32'(m_any_e));
    smp_valid = '0; clr_err = '0; clr_oos = '0;
    smp_data  = {$urandom, $urandom};
  endtask

  task automatic send(input int c, input bit corrupt, input logic lng_gen, input string req);
    logic [HW-1:0] hn;
    logic [W-1:0]  v;
    v = f_pred(g_hist[c], lng_gen, hn);
    g_hist[c] = hn;
    smp_valid[c] = 1'b1;
    smp_data[c*W +: W] = corrupt ? ~v : v;
    tick(req);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    g_hist[0] = 23'h1A5F3C;
    g_hist[1] = 23'h0773B1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values visible before any sample
    check("R1", 32'(oos_flag), 32'h3);
    check("R1", 32'(err_flag), 32'h0);
    check("R1", 32'(any_oos), 32'h1);
    check("R1", 32'(any_err), 32'h0);

    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic lng;
        lng = s[0];
        pn_long[c] = lng;
        // R2: the other sequence type never locks
        for (int k = 0; k < 40; k++) send(c, 1'b0, ~lng, "R2");
        clr_oos[c] = 1'b1; tick("R7");
        check("R2", 32'(oos_flag[c]), 32'h1);
        // R4: self-synchronise and lock on the selected sequence
        for (int k = 0; k < 30; k++) send(c, 1'b0, lng, "R4");
        clr_oos[c] = 1'b1; tick("R7");
        check("R4", 32'(oos_flag[c]), 32'h0);
        // R6/R3: single corrupt sample flags an error, later samples still match
        send(c, 1'b1, lng, "R6");
        check("R6", 32'(err_flag[c]), 32'h1);
        for (int k = 0; k < 20; k++) send(c, 1'b0, lng, "R3");
        check("R3", 32'(oos_flag[c]), 32'h0);
        // R7: new error beats clear in the same cycle
        smp_valid[c] = 1'b1; clr_err[c] = 1'b1;
        begin
          logic [HW-1:0] hn; logic [W-1:0] v;
          v = f_pred(g_hist[c], lng, hn); g_hist[c] = hn;
          smp_data[c*W +: W] = ~v;
        end
        tick("R7");
        check("R7", 32'(err_flag[c]), 32'h1);
        clr_err[c] = 1'b1; tick("R7");
        check("R7", 32'(err_flag[c]), 32'h0);
        // R8: idle cycles with junk data change nothing
        for (int k = 0; k < 12; k++) tick("R8");
        for (int k = 0; k < 5; k++) send(c, 1'b0, lng, "R8");
        check("R8", 32'(err_flag[c]), 32'h0);
        clr_err[c] = 1'b1; tick("R7");
        // R5: 63 misses, one match restarts the run
        for (int k = 0; k < 63; k++) send(c, 1'b1, lng, "R5");
        send(c, 1'b0, lng, "R5");
        for (int k = 0; k < 63; k++) send(c, 1'b1, lng, "R5");
        check("R5", 32'(oos_flag[c]), 32'h0);
        send(c, 1'b1, lng, "R5");
        check("R5", 32'(oos_flag[c]), 32'h1);
        check("R6", 32'(err_flag[c]), 32'h0);
        // R7: clearing the lost-lock flag while still out of lock has no effect
        clr_oos[c] = 1'b1; tick("R7");
        check("R7", 32'(oos_flag[c]), 32'h1);
        // R4: relock after loss
        for (int k = 0; k < 30; k++) send(c, 1'b0, lng, "R4");
        clr_oos[c] = 1'b1; tick("R7");
        check("R4", 32'(oos_flag[c]), 32'h0);
        // switch the select while locked: runs lose lock again
        pn_long[c] = ~lng;
        for (int k = 0; k < 70; k++) send(c, 1'b0, lng, "R5");
        check("R5", 32'(oos_flag[c]), 32'h1);
        clr_err[c] = 1'b1; tick("R7");
      end
    end
    for (int k = 0; k < 3; k++) tick("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule